// File: doc/BRIEF.md
# ADC serial output port

This block is the device-side digital serial port of a delta-sigma converter. When a conversion finishes it captures the result in a holding register. A host then clocks the result out on SDO while it clocks a configuration word in on SDI. A single line does double duty. Before any data bit, SDO tells the host whether a conversion is still running (1) or a result is waiting (0). At the end of a full 32-clock frame the port starts the next conversion and SDO rises again.

The serial clock can come from either side. At each falling edge of chip select the port samples the SCK line, which is weakly pulled up while CS is high. If the host holds SCK low, the host clocks the frame. If the line floats high, the port drives SCK itself. In that case it waits an end-of-conversion test interval and then toggles SCK with a fixed half period. The interval is a system-clock count when the internal oscillator is used. With an external oscillator it is a fixed-point accumulation of oscillator ticks. The modulator and filter are outside the block: a strobe with a 30-bit result stands in for them. The system clock is taken to be much faster than SCK, and all pad inputs are synchronous to it.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, SDO and SCK are not driven, `start_conv` is low, all configuration outputs are 0, and the port is in the converting state.
- R2: `sdo_oe` is low in every cycle in which `cs_n` is high and high in every cycle in which it is low.
- R3: While a conversion runs, SDO reads 1. After `conv_done` is accepted (it is accepted only while converting), SDO reads 0 from the next cycle, including when CS is already low.
- R4: The 32-bit output word is {EOC=0, 0, result[29:0]} and is sent MSB first. SDO shows bit 31 before the first SCK edge and moves to the next bit one system clock after each SCK falling edge is seen.
- R5: SDI is sampled on SCK rising edges. Input bits 29 down to 19 (counting from bit 31, the first sent) become, in order, en, sgl, odd, addr[2], addr[1], addr[0], en2, im, fa, fb and spd. All other input bits have no effect.
- R6: On the 32nd SCK falling edge SDO goes to 1 and the received fields are applied. `start_conv` then pulses high for exactly one cycle, in the cycle after.
- R7: A frame ended by CS rising before 32 falling edges leaves the configuration unchanged and gives no `start_conv`. The held result is sent again, from bit 31, at the next CS falling edge.
- R8: `sck_pu` is high while CS is high and in the cycle in which its falling edge is taken. SCK high at that edge selects internal clocking. SCK low selects external clocking, in which `sck_oe` stays low.
- R9: In internal clocking with a result ready, the port drives SCK low from the second cycle after CS falls. The first SCK rise is seen EOC_CYC+1 cycles after CS falls. SCK then toggles every SCK_HALF cycles until the 32nd falling edge.
- R10: With `ext_osc` high, the first internal SCK rise comes on the oscillator tick at which TEST_DEN times the number of ticks since CS fell first reaches TEST_NUM (four ticks by default).
- R11: If CS rises before the first internal SCK rise, no SCK edge is produced and the result stays held for the next frame.
- R12: SCK edges that arrive while a conversion runs do not shift data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck_in | input | 1 | Level seen on the SCK pad |
| sdi | input | 1 | Serial configuration input |
| conv_done | input | 1 | Conversion finished strobe |
| conv_res | input | 30 | Sign plus data bits of the finished conversion |
| osc_tick | input | 1 | One-cycle pulse per external oscillator period |
| ext_osc | input | 1 | Time the test interval with oscillator ticks |
| sck_out | output | 1 | SCK level driven in internal clocking |
| sck_oe | output | 1 | SCK pad drive enable |
| sck_pu | output | 1 | Weak pull-up enable for the SCK pad |
| sdo | output | 1 | Serial data / end-of-conversion output |
| sdo_oe | output | 1 | SDO pad drive enable (low means high impedance) |
| start_conv | output | 1 | Start-of-conversion pulse |
| cfg_en | output | 1 | Received enable field |
| cfg_sgl | output | 1 | Received single-ended field |
| cfg_odd | output | 1 | Received polarity field |
| cfg_addr | output | 3 | Received channel address |
| cfg_en2 | output | 1 | Received second enable field |
| cfg_im | output | 1 | Received input-monitor field |
| cfg_fa | output | 1 | Received filter field A |
| cfg_fb | output | 1 | Received filter field B |
| cfg_spd | output | 1 | Received speed field |

## Verification
The host model runs full frames and aborted frames with both clock sources. This separates a correct bit counter from one that finishes early or late, and shows that configuration is applied only on completion. External-clock frames start from a CS low held across a conversion, with SCK toggled while the conversion runs, which tells ignored edges from shifted ones. Internal-clock frames use the cycle-count timer and then the oscillator-tick accumulator, so the exact cycle and tick count of the first SCK rise pins down each timer. An aborted internal poll followed by a replayed word shows that the result is held rather than consumed.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int EOC_CYC  = 1200,
  parameter int SCK_HALF = 4,
  parameter int TEST_NUM = 36,
  parameter int TEST_DEN = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck_in,
  input  logic        sdi,
  input  logic        conv_done,
  input  logic [29:0] conv_res,
  input  logic        osc_tick,
  input  logic        ext_osc,
  output logic        sck_out,
  output logic        sck_oe,
  output logic        sck_pu,
  output logic        sdo,
  output logic        sdo_oe,
  output logic        start_conv,
  output logic        cfg_en,
  output logic        cfg_sgl,
  output logic        cfg_odd,
  output logic [2:0]  cfg_addr,
  output logic        cfg_en2,
  output logic        cfg_im,
  output logic        cfg_fa,
  output logic        cfg_fb,
  output logic        cfg_spd
);
  localparam int TW = (EOC_CYC > 1) ? $clog2(EOC_CYC) : 1;
  localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int AW = $clog2(TEST_NUM + TEST_DEN + 1);

  logic          cs_q, sck_q, int_mode, eoc, gen_on, gen_sck, start_q;
  logic [TW-1:0] tmr;
  logic [HW-1:0] hcnt;
  logic [AW-1:0] acc;
  logic [31:0]   sr;
  logic [29:0]   res_q;
  logic [10:0]   rx, cfg_q;
  logic [4:0]    cnt;

  logic cs_fall, act, sck_rise, sck_fall, last, wait_on, acc_hit;

  assign cs_fall  = cs_q & ~cs_n;
  assign act      = ~cs_n & ~cs_q & ~eoc & (~int_mode | gen_on);
  assign sck_rise = act & sck_in & ~sck_q;
  assign sck_fall = act & ~sck_in & sck_q;
  assign last     = sck_fall & (cnt == 5'd31);
  assign wait_on  = int_mode & ~cs_n & ~cs_q & ~eoc & ~gen_on;
  assign acc_hit  = (int'(acc) + TEST_DEN) >= TEST_NUM;

  // pad control and interval timing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sck_q    <= 1'b1;
      int_mode <= 1'b0;
      gen_on   <= 1'b0;
      gen_sck  <= 1'b0;
      tmr      <= '0;
      acc      <= '0;
      hcnt     <= '0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck_in;
      if (cs_fall) begin
        int_mode <= sck_in;
        tmr      <= '0;
        acc      <= '0;
      end else if (wait_on) begin
        if (ext_osc) begin
          if (osc_tick) begin
            if (acc_hit) begin
              gen_on  <= 1'b1;
              gen_sck <= 1'b1;
              hcnt    <= '0;
            end else begin
              acc <= acc + AW'(TEST_DEN);
            end
          end
        end else if (tmr == TW'(EOC_CYC - 1)) begin
          gen_on  <= 1'b1;
          gen_sck <= 1'b1;
          hcnt    <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
      if (gen_on) begin
        if (cs_n || eoc) begin
          gen_on  <= 1'b0;
          gen_sck <= 1'b0;
        end else if (hcnt == HW'(SCK_HALF - 1)) begin
          hcnt    <= '0;
          gen_sck <= ~gen_sck;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  // result holding, shifting and configuration capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoc     <= 1'b1;
      sr      <= '0;
      res_q   <= '0;
      cnt     <= '0;
      rx      <= '0;
      cfg_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= last;
      if (conv_done && eoc) begin
        res_q <= conv_res;
        sr    <= {2'b00, conv_res};
        eoc   <= 1'b0;
        cnt   <= '0;
      end else if (cs_fall && !eoc) begin
        sr  <= {2'b00, res_q};
        cnt <= '0;
      end else if (sck_fall) begin
        sr  <= {sr[30:0], 1'b0};
        cnt <= cnt + 1'b1;
        if (last) begin
          eoc   <= 1'b1;
          cfg_q <= rx;
        end
      end
      if (sck_rise && cnt >= 5'd2 && cnt <= 5'd12)
        rx <= {rx[9:0], sdi};
    end
  end

  assign sdo        = eoc | sr[31];
  assign sdo_oe     = ~cs_n;
  assign sck_oe     = int_mode & ~cs_n & ~cs_q;
  assign sck_out    = gen_sck;
  assign sck_pu     = cs_q;
  assign start_conv = start_q;
  assign {cfg_en, cfg_sgl, cfg_odd, cfg_addr, cfg_en2, cfg_im, cfg_fa, cfg_fb, cfg_spd} = cfg_q;

  p_done_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && eoc) |=> (!eoc && !sdo));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv);

  p_end_eoc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> (eoc && sdo));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_conv |-> $stable(cfg_q));

  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !conv_done) |=> $stable(sr));
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
  localparam int EOC_CYC  = 40;
  localparam int SCK_HALF = 3;
  localparam int TICK_DIV = 7;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic host_drv = 1'b1, host_sck = 1'b0;
  logic conv_done = 1'b0, osc_tick = 1'b0, ext_osc = 1'b0;
  logic [29:0] conv_res = '0;
  logic sck_out, sck_oe, sck_pu, sdo, sdo_oe, start_conv;
  logic cfg_en, cfg_sgl, cfg_odd, cfg_en2, cfg_im, cfg_fa, cfg_fb, cfg_spd;
  logic [2:0] cfg_addr;
  logic sck_line;
  logic [10:0] cfg_bus;
  int checks = 0, errors = 0, starts = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sck_line = sck_oe ? sck_out : (host_drv ? host_sck : 1'b1);
  assign cfg_bus  = {cfg_en, cfg_sgl, cfg_odd, cfg_addr, cfg_en2, cfg_im, cfg_fa, cfg_fb, cfg_spd};

  adc_serial_port #(.EOC_CYC(EOC_CYC), .SCK_HALF(SCK_HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_in(sck_line), .sdi(sdi),
    .conv_done(conv_done), .conv_res(conv_res), .osc_tick(osc_tick), .ext_osc(ext_osc),
    .sck_out(sck_out), .sck_oe(sck_oe), .sck_pu(sck_pu), .sdo(sdo), .sdo_oe(sdo_oe),
    .start_conv(start_conv), .cfg_en(cfg_en), .cfg_sgl(cfg_sgl), .cfg_odd(cfg_odd),
    .cfg_addr(cfg_addr), .cfg_en2(cfg_en2), .cfg_im(cfg_im), .cfg_fa(cfg_fa),
    .cfg_fb(cfg_fb), .cfg_spd(cfg_spd));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_conv(input logic [29:0] r);
    conv_res = r;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  // per-cycle reference: pad enable follows chip select, start pulses are counted
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(sdo_oe == !cs_n, "R2 sdo_oe", {31'd0, sdo_oe}, {31'd0, !cs_n});
      if (start_conv) starts++;
    end
  end

  // host-clocked frame; CS already low and result ready
  task automatic ext_frame(input logic [31:0] tx, input int nbits, input logic [29:0] r);
    logic [31:0] w;
    w = {2'b00, r};
    chk(sck_oe == 1'b0, "R8 ext no drive", {31'd0, sck_oe}, 0);
    chk(sdo == w[31], "R4 first bit", {31'd0, sdo}, {31'd0, w[31]});
    for (int i = 0; i < nbits; i++) begin
      sdi = tx[31-i];
      cyc(2);
      host_sck = 1'b1;
      cyc(3);
      host_sck = 1'b0;
      cyc(3);
      if (i < 31) chk(sdo == w[30-i], "R4 data bit", {31'd0, sdo}, {31'd0, w[30-i]});
      else        chk(sdo == 1'b1, "R6 eoc after frame", {31'd0, sdo}, 1);
    end
  endtask

  // port-clocked frame; CS falls here with the SCK line floating
  task automatic int_frame(input logic [31:0] tx, input logic [29:0] r, input bit use_osc);
    logic [31:0] w;
    int n, ticks;
    w = {2'b00, r};
    n = 0;
    ticks = 0;
    sdi = tx[31];
    chk(sck_pu == 1'b1, "R8 pull-up before CS", {31'd0, sck_pu}, 1);
    cs_n = 1'b0;
    while (1) begin
      @(negedge clk);
      n++;
      if (sck_oe && sck_line) break;
      if (n == 2) begin
        chk(sck_oe && !sck_line, "R9 SCK driven low", {30'd0, sck_oe, sck_line}, 2);
        chk(sdo == 1'b0, "R3 ready at poll", {31'd0, sdo}, 0);
      end
      if (use_osc && (n % TICK_DIV == 0)) begin
        osc_tick = 1'b1;
        ticks++;
      end else begin
        osc_tick = 1'b0;
      end
    end
    osc_tick = 1'b0;
    if (use_osc) chk(ticks == 4, "R10 ticks to first rise", ticks, 4);
    else         chk(n == EOC_CYC + 1, "R9 cycles to first rise", n, EOC_CYC + 1);
    chk(sdo == w[31], "R4 first bit", {31'd0, sdo}, {31'd0, w[31]});
    for (int i = 0; i < 32; i++) begin
      while (sck_line) @(negedge clk);
      if (i < 31) sdi = tx[30-i];
      @(negedge clk);
      if (i < 31) chk(sdo == w[30-i], "R4 data bit int", {31'd0, sdo}, {31'd0, w[30-i]});
      else        chk(sdo == 1'b1, "R6 eoc after int frame", {31'd0, sdo}, 1);
      if (i < 31) while (!sck_line) @(negedge clk);
    end
  endtask

  task automatic cs_up;
    cs_n = 1'b1;
    cyc(3);
  endtask

  initial begin
    logic [31:0] tx_a, tx_b, tx_c, tx_d, tx_e;
    logic [10:0] cfg_prev;
    int s0;
    bit saw;
    tx_a = 32'hA5C3_1234;
    tx_b = 32'hBFFF_FFFF;
    tx_c = 32'h9A6E_7C21;
    tx_d = 32'hB3A8_F00F;
    tx_e = 32'h8C51_0F0F;

    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    chk(sdo_oe == 1'b0 && sck_oe == 1'b0, "R1 pads idle", {30'd0, sdo_oe, sck_oe}, 0);
    chk(start_conv == 1'b0, "R1 no start", {31'd0, start_conv}, 0);
    chk(cfg_bus == 11'd0, "R1 cfg zero", {21'd0, cfg_bus}, 0);
    chk(sck_pu == 1'b1, "R8 pull-up while CS high", {31'd0, sck_pu}, 1);

    // external clock, poll while converting, edges ignored while busy
    cs_n = 1'b0;
    cyc(2);
    chk(sdo == 1'b1, "R1 R3 converting after reset", {31'd0, sdo}, 1);
    for (int k = 0; k < 3; k++) begin
      host_sck = 1'b1; cyc(3); host_sck = 1'b0; cyc(3);
    end
    chk(sdo == 1'b1, "R12 edges while busy", {31'd0, sdo}, 1);
    do_conv(30'h2BCD_1357);
    chk(sdo == 1'b0, "R3 done while CS low", {31'd0, sdo}, 0);
    s0 = starts;
    ext_frame(tx_a, 32, 30'h2BCD_1357);
    cyc(2);
    chk(starts == s0 + 1, "R6 one start pulse", starts, s0 + 1);
    chk(cfg_bus == tx_a[29:19], "R5 cfg from frame A", {21'd0, cfg_bus}, {21'd0, tx_a[29:19]});
    cs_up();

    // aborted external frame then replay
    do_conv(30'h1F0F_00F0);
    cs_n = 1'b0;
    cyc(2);
    s0 = starts;
    cfg_prev = cfg_bus;
    ext_frame(tx_b, 10, 30'h1F0F_00F0);
    cs_up();
    chk(starts == s0, "R7 no start on abort", starts, s0);
    chk(cfg_bus == cfg_prev, "R7 cfg kept on abort", {21'd0, cfg_bus}, {21'd0, cfg_prev});
    cs_n = 1'b0;
    cyc(2);
    ext_frame(tx_c, 32, 30'h1F0F_00F0);
    cyc(2);
    chk(starts == s0 + 1, "R6 R7 replay completes", starts, s0 + 1);
    chk(cfg_bus == tx_c[29:19], "R5 cfg from frame C", {21'd0, cfg_bus}, {21'd0, tx_c[29:19]});
    cs_up();

    // internal clock, cycle-counted interval
    do_conv(30'h3A5A_5A5A);
    host_drv = 1'b0;
    cyc(2);
    s0 = starts;
    int_frame(tx_d, 30'h3A5A_5A5A, 1'b0);
    cyc(2);
    chk(starts == s0 + 1, "R6 int start pulse", starts, s0 + 1);
    chk(cfg_bus == tx_d[29:19], "R5 cfg from int frame", {21'd0, cfg_bus}, {21'd0, tx_d[29:19]});
    cs_up();

    // internal poll aborted before first rise
    do_conv(30'h0123_4567);
    cyc(2);
    s0 = starts;
    cfg_prev = cfg_bus;
    saw = 0;
    cs_n = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k >= 1 && sck_oe && sck_line) saw = 1;
    end
    cs_up();
    chk(!saw, "R11 no SCK edge on early CS rise", {31'd0, saw}, 0);
    chk(starts == s0 && cfg_bus == cfg_prev, "R11 nothing applied",
        {21'd0, cfg_bus}, {21'd0, cfg_prev});

    // internal clock with oscillator-tick interval; replays held word
    ext_osc = 1'b1;
    cyc(2);
    int_frame(tx_e, 30'h0123_4567, 1'b1);
    cyc(2);
    chk(starts == s0 + 1, "R10 R11 replay after abort", starts, s0 + 1);
    chk(cfg_bus == tx_e[29:19], "R5 cfg from osc frame", {21'd0, cfg_bus}, {21'd0, tx_e[29:19]});
    cs_up();
    chk(sdo_oe == 1'b0, "R2 released", {31'd0, sdo_oe}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule